// File: doc/BRIEF.md
# Toggle-Write Interrupt Status Unit

This block gathers the interrupt sources of a serial-port peripheral into one level interrupt line. It keeps three registers. The first is a status word that software updates by XOR: every 1 written flips the matching bit. The second is a per-bit enable mask. The third is a master enable that holds a single flag in bit 31.

Single-cycle pulses from the FIFO controller set status bits. So does the end of each byte exchange. Two receive-side bits are also refreshed from live FIFO level signals on every register access. Because of this, software cannot keep either bit cleared while its condition lasts.

The register port is a plain 32-bit read/write interface addressed by word index. Reads are combinational from the registers. The interrupt output is registered and changes on the same clock edge that updates the registers behind it.

Top module: `tgl_irq_ctl`

## Requirements
- R1: After reset, the status, enable and master-enable registers all read 0, and `irq` is 0.
- R2: A write at word index 0x08 (status) stores the old status XOR `reg_wdata` on all 32 bits, when no hardware set applies to the same bit.
- R3: A write at word index 0x0A (enable) stores the full 32-bit word. A write at word index 0x07 (master enable) keeps only bit 31, and a read of that index returns 0 in bits 30..0.
- R4: `irq` is 1 exactly when master-enable bit 31 is 1 and some bit is 1 in both status and enable. It takes its new value on the edge that records the write or event.
- R5: A `xfer_done` pulse sets status bit 2 (transmit empty) and bit 8 (receive not empty).
- R6: Event pulses set single status bits: `rx_overrun_evt` sets bit 5, `rx_full_evt` sets bit 4, `tx_half_evt` sets bit 6 and `tx_underrun_evt` sets bit 3.
- R7: In any cycle with `reg_wr` or `reg_rd` high, status bit 8 is set if `rx_has_data` is 1, and bit 4 is set if `rx_is_full` is 1. Without an access, the level inputs change nothing.
- R8: If a hardware set and a software toggle hit the same status bit in one cycle, the bit ends at 1.
- R9: A read of any other word index returns 0. A write to any other word index changes no register.
- R10: `irq` changes only on a rising clock edge, and it holds its value across a cycle with no access and no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (counts as an access) |
| reg_addr | input | ADDR_W | Word index of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| rx_has_data | input | 1 | Level: receive FIFO is not empty |
| rx_is_full | input | 1 | Level: receive FIFO is full |
| xfer_done | input | 1 | Pulse: one byte exchange has completed |
| rx_overrun_evt | input | 1 | Pulse: a received byte was lost |
| rx_full_evt | input | 1 | Pulse: receive FIFO became full |
| tx_half_evt | input | 1 | Pulse: transmit FIFO is half empty |
| tx_underrun_evt | input | 1 | Pulse: transmit FIFO ran dry |
| irq | output | 1 | Level interrupt request |

## Verification
Every register update and the `irq` output appear one rising edge after the write, access or pulse that causes them. The bench drives each stimulus on a falling edge and removes it on the next falling edge, then reads the result just after that falling edge. To show that `irq` is registered, the bench also samples it before the edge, where it must still hold its old value. Register contents are read at the combinational read port with both strobes low, so the level-refresh rule of R7 does not disturb the observation.

// File: rtl/tgl_irq_ctl.sv
module tgl_irq_ctl #(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 32,
  parameter int GIE_IDX    = 7,
  parameter int ISR_IDX    = 8,
  parameter int IER_IDX    = 10,
  parameter int GIE_BIT    = 31,
  parameter int RNE_BIT    = 8,
  parameter int THALF_BIT  = 6,
  parameter int OVR_BIT    = 5,
  parameter int RFULL_BIT  = 4,
  parameter int TUDR_BIT   = 3,
  parameter int TEMPTY_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              rx_has_data,
  input  logic              rx_is_full,
  input  logic              xfer_done,
  input  logic              rx_overrun_evt,
  input  logic              rx_full_evt,
  input  logic              tx_half_evt,
  input  logic              tx_underrun_evt,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] A_GIE = ADDR_W'(GIE_IDX);
  localparam logic [ADDR_W-1:0] A_ISR = ADDR_W'(ISR_IDX);
  localparam logic [ADDR_W-1:0] A_IER = ADDR_W'(IER_IDX);

  logic [DATA_W-1:0] isr_q, ier_q, isr_d, ier_d, hw_set;
  logic              gie_q, gie_d, irq_d;

  wire access = reg_wr | reg_rd;
  wire sel_gie = reg_addr == A_GIE;
  wire sel_isr = reg_addr == A_ISR;
  wire sel_ier = reg_addr == A_IER;
  wire any_evt = xfer_done | rx_overrun_evt | rx_full_evt | tx_half_evt | tx_underrun_evt;

  always_comb begin
    hw_set = '0;
    hw_set[TEMPTY_BIT] = xfer_done;
    hw_set[RNE_BIT]    = xfer_done | (access & rx_has_data);
    hw_set[OVR_BIT]    = rx_overrun_evt;
    hw_set[RFULL_BIT]  = rx_full_evt | (access & rx_is_full);
    hw_set[THALF_BIT]  = tx_half_evt;
    hw_set[TUDR_BIT]   = tx_underrun_evt;
  end

  assign isr_d = ((reg_wr && sel_isr) ? (isr_q ^ reg_wdata) : isr_q) | hw_set;
  assign ier_d = (reg_wr && sel_ier) ? reg_wdata : ier_q;
  assign gie_d = (reg_wr && sel_gie) ? reg_wdata[GIE_BIT] : gie_q;
  assign irq_d = gie_d & (|(isr_d & ier_d));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q <= '0;
      ier_q <= '0;
      gie_q <= 1'b0;
      irq   <= 1'b0;
    end else begin
      isr_q <= isr_d;
      ier_q <= ier_d;
      gie_q <= gie_d;
      irq   <= irq_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (sel_isr) reg_rdata = isr_q;
    else if (sel_ier) reg_rdata = ier_q;
    else if (sel_gie) reg_rdata[GIE_BIT] = gie_q;
  end

  p_gie_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_q |-> !irq);

  p_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && sel_isr && !any_evt && !rx_has_data && !rx_is_full)
    |=> isr_q == ($past(isr_q) ^ $past(reg_wdata)));

  p_xfer_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> isr_q[TEMPTY_BIT] && isr_q[RNE_BIT]);

  p_overrun_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun_evt |=> isr_q[OVR_BIT]);

  p_level_refresh_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (access && rx_has_data) |=> isr_q[RNE_BIT]);

  p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!access && !any_evt) |=> $stable(irq));

endmodule

// File: tb/test_tgl_irq_ctl.sv
`timescale 1ns/1ps
module test_tgl_irq_ctl;
  localparam int A_GIE = 7, A_ISR = 8, A_IER = 10;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [5:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic rx_has_data = 0, rx_is_full = 0, xfer_done = 0;
  logic rx_overrun_evt = 0, rx_full_evt = 0, tx_half_evt = 0, tx_underrun_evt = 0;
  logic irq;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  tgl_irq_ctl i_tgl_irq_ctl (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = 6'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input int a);
    @(negedge clk);
    reg_rd = 1; reg_addr = 6'(a);
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic peek(input int a, output logic [31:0] v);
    reg_addr = 6'(a);
    #0.5;
    v = reg_rdata;
  endtask

  task automatic clr_isr();
    logic [31:0] v;
    peek(A_ISR, v);
    if (v != 0) wr(A_ISR, v);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v, ip, ep;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    peek(A_ISR, v); chk("R1 isr", v, 0);
    peek(A_IER, v); chk("R1 ier", v, 0);
    peek(A_GIE, v); chk("R1 gie", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R3 enable and master enable storage
    wr(A_IER, 32'h1234_5678); peek(A_IER, v); chk("R3 ier", v, 32'h1234_5678);
    wr(A_GIE, 32'hFFFF_FFFF); peek(A_GIE, v); chk("R3 gie", v, 32'h8000_0000);
    wr(A_GIE, 32'h7FFF_FFFF); peek(A_GIE, v); chk("R3 gie clr", v, 0);
    wr(A_IER, 0);

    // R2 toggle sweep over every bit
    for (int b = 0; b < 32; b++) begin
      wr(A_ISR, 32'(1) << b); peek(A_ISR, v); chk("R2 set", v, 32'(1) << b);
      wr(A_ISR, 32'(1) << b); peek(A_ISR, v); chk("R2 back", v, 0);
    end
    wr(A_ISR, 32'hA5A5_A5A5);
    wr(A_ISR, 32'hFFFF_0000); peek(A_ISR, v); chk("R2 xor", v, 32'h5A5A_A5A5);
    clr_isr(); peek(A_ISR, v); chk("R2 clear", v, 0);

    // R4 sweep: status/enable over bits 2,5,8 and master enable
    for (int i = 0; i < 128; i++) begin
      ip = (32'(i & 1) << 2) | (32'((i >> 1) & 1) << 5) | (32'((i >> 2) & 1) << 8);
      ep = (32'((i >> 3) & 1) << 2) | (32'((i >> 4) & 1) << 5) | (32'((i >> 5) & 1) << 8);
      wr(A_ISR, ip);
      wr(A_IER, ep);
      wr(A_GIE, 32'((i >> 6) & 1) << 31);
      chk("R4 irq", {31'b0, irq}, {31'b0, ((i >> 6) & 1) == 1 && (ip & ep) != 0});
      wr(A_ISR, ip);
    end
    wr(A_GIE, 0); wr(A_IER, 0);

    // R10 registered output with R5 pulse
    wr(A_IER, 32'h4); wr(A_GIE, 32'h8000_0000);
    @(negedge clk); xfer_done = 1;
    #1 chk("R10 before edge", {31'b0, irq}, 0);
    @(negedge clk); xfer_done = 0;
    chk("R10 after edge", {31'b0, irq}, 1);
    peek(A_ISR, v); chk("R5 xfer bits", v, 32'h104);
    repeat (3) @(negedge clk);
    chk("R10 hold", {31'b0, irq}, 1);
    clr_isr(); chk("R4 irq drop", {31'b0, irq}, 0);
    wr(A_GIE, 0); wr(A_IER, 0);

    // R6 single event pulses
    @(negedge clk); rx_overrun_evt = 1; @(negedge clk); rx_overrun_evt = 0;
    peek(A_ISR, v); chk("R6 overrun", v, 32'h20); clr_isr();
    @(negedge clk); rx_full_evt = 1; @(negedge clk); rx_full_evt = 0;
    peek(A_ISR, v); chk("R6 full", v, 32'h10); clr_isr();
    @(negedge clk); tx_half_evt = 1; @(negedge clk); tx_half_evt = 0;
    peek(A_ISR, v); chk("R6 half", v, 32'h40); clr_isr();
    @(negedge clk); tx_underrun_evt = 1; @(negedge clk); tx_underrun_evt = 0;
    peek(A_ISR, v); chk("R6 underrun", v, 32'h08); clr_isr();

    // R7 level refresh only on access
    @(negedge clk); rx_has_data = 1; rx_is_full = 1;
    repeat (3) @(negedge clk);
    peek(A_ISR, v); chk("R7 idle no effect", v, 0);
    rd(3); peek(A_ISR, v); chk("R7 read refresh", v, 32'h110);
    wr(A_ISR, 32'h110); peek(A_ISR, v); chk("R7 cannot clear", v, 32'h110);
    @(negedge clk); rx_has_data = 0; rx_is_full = 0;
    wr(A_ISR, 32'h110); peek(A_ISR, v); chk("R7 clear after drop", v, 0);

    // R8 hardware set wins over toggle
    wr(A_ISR, 32'h20);
    @(negedge clk); reg_wr = 1; reg_addr = A_ISR; reg_wdata = 32'h21; rx_overrun_evt = 1;
    @(negedge clk); reg_wr = 0; rx_overrun_evt = 0;
    peek(A_ISR, v); chk("R8 hw wins", v, 32'h21);
    clr_isr();

    // R9 unmapped access
    wr(A_IER, 32'h0F0F_0000); wr(A_GIE, 32'h8000_0000); wr(A_ISR, 32'h3);
    wr(9, 32'hFFFF_FFFF); wr(0, 32'hFFFF_FFFF);
    peek(A_ISR, v); chk("R9 isr kept", v, 32'h3);
    peek(A_IER, v); chk("R9 ier kept", v, 32'h0F0F_0000);
    peek(A_GIE, v); chk("R9 gie kept", v, 32'h8000_0000);
    peek(9, v); chk("R9 read zero", v, 0);

    // R1 reset again clears everything
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    peek(A_ISR, v); chk("R1 isr after", v, 0);
    peek(A_IER, v); chk("R1 ier after", v, 0);
    peek(A_GIE, v); chk("R1 gie after", v, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule